// File: doc/BRIEF.md
# Per-Channel Interrupt Notification Manager

This block turns per-channel events in a multi-channel host interface into a single host interrupt. Each channel has an arm bit. The first event on an armed channel posts a notification and disarms the channel. The channel then stays quiet until the driver arms it again. Events on a disarmed channel are not lost. They collect in a per-channel pending vector and are posted when the driver re-arms the channel.

Notifications sit in a short ordered list. Each entry holds a channel number and an event vector. Further events for a channel that already has an entry are ORed into that entry, so no second entry is added. The host pops the list by pulsing a read strobe. The popped word appears on `rd_data` on the next cycle. The interrupt line stays high for as long as the list holds anything.

Top module: `inm_irq_notify`

## Requirements
- R1: After reset the interrupt and the overflow flag are low, `rd_data` is zero, the list is empty and every channel is disarmed.
- R2: An event on an armed channel that has no list entry appends the entry {channel, vector} at the tail of the list and disarms the channel, provided the list has room.
- R3: An event on a disarmed channel that has no list entry ORs its vector into that channel's pending vector. It adds no entry and raises no interrupt. A channel stays disarmed until a host write arms it.
- R4: An arm write (`wr_en`=1, `wr_arm`=1) to a channel whose pending vector is nonzero posts that vector as a new entry, clears the pending vector and leaves the channel disarmed. If the pending vector is zero, the write arms the channel.
- R5: An event for a channel that already has a list entry ORs its vector into that entry. The entry count does not change, and no channel ever has two entries.
- R6: A pulse of `rd_en` on a non-empty list removes the head entry. On the next cycle `rd_data` holds {1, channel, vector}: bit 13 is the valid bit, bits 12:5 the channel and bits 4:0 the vector (default parameters). Entries come out in the order they were posted.
- R7: A pulse of `rd_en` on an empty list makes `rd_data` all zero on the next cycle, valid bit included.
- R8: `irq` is high exactly while the list is non-empty. It goes low on the cycle after the read that empties the list.
- R9: An entry that is needed while the list already holds DEPTH entries is not posted. Its bits stay in the pending vector, the channel is disarmed, and `ovf` is set and stays set until reset.
- R10: `ev_desc` marks an event caused by a specially marked descriptor. It appears as vector bit EVW (bit 4 by default). The `ev_kind` bits occupy bits 3:0. An event whose vector is all zero has no effect.
- R11: Operations in one cycle take effect in a fixed order: first the pop, then the host write, then the event. An event for a channel whose entry is popped in the same cycle goes to the pending vector and is not returned by that read.
- R12: A disarm write (`wr_en`=1, `wr_arm`=0) clears the channel's arm bit and leaves its pending vector unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event strobe |
| ev_ch | input | CHW (8) | Channel number of the event |
| ev_kind | input | EVW (4) | Event kind bits |
| ev_desc | input | 1 | Event comes from a marked descriptor |
| rd_en | input | 1 | Read pulse on the notification register; pops one entry |
| rd_data | output | RDW (14) | Last word read: {valid, channel, vector} |
| wr_en | input | 1 | Host write to a channel's arm bit |
| wr_ch | input | CHW (8) | Channel number of the write |
| wr_arm | input | 1 | Value written: 1 arms, 0 disarms |
| irq | output | 1 | Interrupt; high while the list is non-empty |
| ovf | output | 1 | Sticky flag: a notification could not be posted because the list was full |

## Verification
The critical collision is a pop of a channel's entry in the same cycle as a new event for that channel. If the entry were merged before the pop, the read would return the new bits. If the event were dropped, the bits would vanish.

The bench provokes this directly. It then provokes it repeatedly with pseudo-random traffic on eight channels, where reads, arm writes and events land together. In the same traffic, arm writes and events to the same channel also coincide, in the same cycle.

A behavioural model applies pop, then write, then event each cycle. It is compared every cycle against `rd_data`, `irq` and `ovf`. A misplaced merge shows up when the pending bits are later posted and read.

// File: rtl/inm_pkg.sv
// Package: shared types for the interrupt notification manager.
// Assumes: nothing beyond IEEE 1800-2017.
package inm_pkg;
    // Outcome of an incoming event after the pop and the host write are applied
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,   // no event, or empty vector
        EV_MERGE = 2'd1,   // ORed into an existing list entry
        EV_HOLD  = 2'd2,   // kept in the channel's pending vector
        EV_POST  = 2'd3    // appended as a new list entry
    } ev_act_e;
endpackage

// File: rtl/inm_chan_tbl.sv
// Module: per-channel arm bit and pending event vector storage.
// Two combinational read ports and two write ports. When both write ports
// address the same channel, port b wins; the caller folds port a's result
// into port b's data in that case.
// Assumes: NUM_CH <= 2**CHW; synchronous active-low reset disarms all channels.
module inm_chan_tbl #(
    parameter int NUM_CH = 256,
    parameter int CHW    = 8,
    parameter int VW     = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CHW-1:0] ra_ch,
    output logic           ra_en,
    output logic [VW-1:0]  ra_pend,
    input  logic [CHW-1:0] rb_ch,
    output logic           rb_en,
    output logic [VW-1:0]  rb_pend,
    input  logic           wa_v,
    input  logic [CHW-1:0] wa_ch,
    input  logic           wa_en,
    input  logic [VW-1:0]  wa_pend,
    input  logic           wb_v,
    input  logic [CHW-1:0] wb_ch,
    input  logic           wb_en,
    input  logic [VW-1:0]  wb_pend
);
    logic          en_q   [NUM_CH];
    logic [VW-1:0] pend_q [NUM_CH];

    // Read ports
    assign ra_en   = en_q[ra_ch];
    assign ra_pend = pend_q[ra_ch];
    assign rb_en   = en_q[rb_ch];
    assign rb_pend = pend_q[rb_ch];

    // Storage update; port b is written last so it takes priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                en_q[i]   <= 1'b0;
                pend_q[i] <= '0;
            end
        end else begin
            if (wa_v) begin
                en_q[wa_ch]   <= wa_en;
                pend_q[wa_ch] <= wa_pend;
            end
            if (wb_v) begin
                en_q[wb_ch]   <= wb_en;
                pend_q[wb_ch] <= wb_pend;
            end
        end
    end
endmodule

// File: rtl/inm_notif_list.sv
// Module: ordered notification list with per-channel merge.
// Within one cycle it applies, in order: a pop of the head, an append from
// port a, then either a merge of the event vector into a matching entry
// (done here, reported on hit_o) or an append from port b.
// Assumes: the caller appends only when the matching free flag is set and
// the channel has no entry; entry 0 is the head.
module inm_notif_list #(
    parameter int DEPTH = 16,
    parameter int CHW   = 8,
    parameter int VW    = 5,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pop_i,
    input  logic           pa_v,
    input  logic [CHW-1:0] pa_ch,
    input  logic [VW-1:0]  pa_vec,
    input  logic           ev_v,
    input  logic [CHW-1:0] ev_ch,
    input  logic [VW-1:0]  ev_vec,
    input  logic           pb_v,
    input  logic [VW-1:0]  pb_vec,
    output logic [CHW-1:0] head_ch,
    output logic [VW-1:0]  head_vec,
    output logic [CW-1:0]  cnt_o,
    output logic           free_a,
    output logic           free_b,
    output logic           hit_o
);
    logic [CHW-1:0] ch_q [DEPTH], ch_p [DEPTH], ch_s [DEPTH], ch_n [DEPTH];
    logic [VW-1:0]  vec_q[DEPTH], vec_p[DEPTH], vec_s[DEPTH], vec_n[DEPTH];
    logic [CW-1:0]  cnt_q, cnt_p, cnt_s, cnt_n;
    logic [CW-1:0]  hit_idx;
    logic           dup;

    // Stage 1: pop the head by shifting every entry down one place
    always_comb begin
        cnt_p = cnt_q;
        for (int i = 0; i < DEPTH; i++) begin
            ch_p[i]  = ch_q[i];
            vec_p[i] = vec_q[i];
        end
        if (pop_i && cnt_q != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                ch_p[i]  = ch_q[i+1];
                vec_p[i] = vec_q[i+1];
            end
            ch_p[DEPTH-1]  = '0;
            vec_p[DEPTH-1] = '0;
            cnt_p = cnt_q - 1'b1;
        end
    end

    assign free_a = (cnt_p < CW'(DEPTH));

    // Stage 2: append from port a at the tail
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ch_s[i]  = ch_p[i];
            vec_s[i] = vec_p[i];
            if (pa_v && CW'(i) == cnt_p) begin
                ch_s[i]  = pa_ch;
                vec_s[i] = pa_vec;
            end
        end
        cnt_s = cnt_p + CW'(pa_v);
    end

    assign free_b = (cnt_s < CW'(DEPTH));

    // Lookup: does the event's channel already own an entry?
    always_comb begin
        hit_o   = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ev_v && CW'(i) < cnt_s && ch_s[i] == ev_ch) begin
                hit_o   = 1'b1;
                hit_idx = CW'(i);
            end
        end
    end

    // Stage 3: merge into the hit entry, or append from port b
    always_comb begin
        cnt_n = cnt_s;
        for (int i = 0; i < DEPTH; i++) begin
            ch_n[i]  = ch_s[i];
            vec_n[i] = vec_s[i];
            if (hit_o && CW'(i) == hit_idx)
                vec_n[i] = vec_s[i] | ev_vec;
            else if (!hit_o && pb_v && CW'(i) == cnt_s) begin
                ch_n[i]  = ev_ch;
                vec_n[i] = pb_vec;
            end
        end
        if (!hit_o && pb_v)
            cnt_n = cnt_s + 1'b1;
    end

    // List registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ch_q[i]  <= '0;
                vec_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_n;
            for (int i = 0; i < DEPTH; i++) begin
                ch_q[i]  <= ch_n[i];
                vec_q[i] <= vec_n[i];
            end
        end
    end

    assign head_ch  = ch_q[0];
    assign head_vec = vec_q[0];
    assign cnt_o    = cnt_q;

    // Pairwise scan of live entries for a repeated channel
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            for (int j = i + 1; j < DEPTH; j++)
                if (CW'(j) < cnt_q && ch_q[i] == ch_q[j])
                    dup = 1'b1;
    end

    // R5
    always_ff @(posedge clk) begin
        if (rst_n) begin
            no_dup_chk: assert (!dup);
        end
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R6
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && cnt_q != '0 && !pa_v && !pb_v) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/inm_irq_notify.sv
// Module: top of the per-channel interrupt notification manager.
// Sequences each cycle as pop, then host arm/disarm write, then event.
// Drives the read word, the interrupt line and the sticky overflow flag.
// Assumes: NUM_CH >= 2; rd_en is a one-cycle pulse per register read.
module inm_irq_notify
    import inm_pkg::*;
#(
    parameter int NUM_CH = 256,
    parameter int EVW    = 4,
    parameter int DEPTH  = 16,
    localparam int CHW   = $clog2(NUM_CH),
    localparam int VW    = EVW + 1,
    localparam int RDW   = 1 + CHW + VW,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ev_valid,
    input  logic [CHW-1:0] ev_ch,
    input  logic [EVW-1:0] ev_kind,
    input  logic           ev_desc,
    input  logic           rd_en,
    output logic [RDW-1:0] rd_data,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_ch,
    input  logic           wr_arm,
    output logic           irq,
    output logic           ovf
);
    logic           en_a, en_b, en_c;
    logic [VW-1:0]  pend_a, pend_b, pend_c;
    logic           wa_v, wa_en, wb_v, wb_en;
    logic [VW-1:0]  wa_pend, wb_pend;
    logic           pa_v, pb_v, ev_v;
    logic [VW-1:0]  ev_vec, pb_vec;
    logic           free_a, free_b, hit;
    logic [CHW-1:0] head_ch;
    logic [VW-1:0]  head_vec;
    logic [CW-1:0]  cnt;
    logic           ovf_w, ovf_e, ovf_q;
    logic [RDW-1:0] rd_q;
    ev_act_e        act;

    assign ev_vec = {ev_desc, ev_kind};
    assign ev_v   = ev_valid && (ev_vec != '0);

    inm_chan_tbl #(.NUM_CH(NUM_CH), .CHW(CHW), .VW(VW)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .ra_ch(wr_ch), .ra_en(en_a), .ra_pend(pend_a),
        .rb_ch(ev_ch), .rb_en(en_b), .rb_pend(pend_b),
        .wa_v(wa_v), .wa_ch(wr_ch), .wa_en(wa_en), .wa_pend(wa_pend),
        .wb_v(wb_v), .wb_ch(ev_ch), .wb_en(wb_en), .wb_pend(wb_pend)
    );

    inm_notif_list #(.DEPTH(DEPTH), .CHW(CHW), .VW(VW)) u_list (
        .clk(clk), .rst_n(rst_n), .pop_i(rd_en),
        .pa_v(pa_v), .pa_ch(wr_ch), .pa_vec(pend_a),
        .ev_v(ev_v), .ev_ch(ev_ch), .ev_vec(ev_vec),
        .pb_v(pb_v), .pb_vec(pb_vec),
        .head_ch(head_ch), .head_vec(head_vec), .cnt_o(cnt),
        .free_a(free_a), .free_b(free_b), .hit_o(hit)
    );

    // Host write: arm (posting any pending bits) or disarm
    always_comb begin
        wa_v    = wr_en;
        wa_en   = en_a;
        wa_pend = pend_a;
        pa_v    = 1'b0;
        ovf_w   = 1'b0;
        if (wr_en) begin
            if (!wr_arm)
                wa_en = 1'b0;
            else if (pend_a == '0)
                wa_en = 1'b1;
            else begin
                wa_en = 1'b0;
                if (free_a) begin
                    pa_v    = 1'b1;
                    wa_pend = '0;
                end else
                    ovf_w = 1'b1;
            end
        end
    end

    // Event: the channel state seen includes this cycle's write to it
    always_comb begin
        en_c   = (wr_en && wr_ch == ev_ch) ? wa_en   : en_b;
        pend_c = (wr_en && wr_ch == ev_ch) ? wa_pend : pend_b;
        if (!ev_v)                act = EV_NONE;
        else if (hit)             act = EV_MERGE;
        else if (en_c && free_b)  act = EV_POST;
        else                      act = EV_HOLD;
        ovf_e   = (act == EV_HOLD) && en_c;
        pb_v    = (act == EV_POST);
        pb_vec  = pend_c | ev_vec;
        wb_v    = (act == EV_POST) || (act == EV_HOLD);
        wb_en   = 1'b0;
        wb_pend = (act == EV_POST) ? '0 : (pend_c | ev_vec);
    end

    // Read word capture and sticky overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (rd_en)
                rd_q <= (cnt != '0) ? {1'b1, head_ch, head_vec} : '0;
            ovf_q <= ovf_q | ovf_w | ovf_e;
        end
    end

    assign rd_data = rd_q;
    assign ovf     = ovf_q;
    assign irq     = (cnt != '0);

    // R7
    empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !irq) |=> rd_data == '0);
    // R6
    full_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && irq) |=> rd_data[RDW-1]);
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_en));
endmodule

// File: tb/inm_irq_notify_bench.sv
`timescale 1ns/1ps
module inm_irq_notify_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0, ev_desc = 1'b0, rd_en = 1'b0;
    logic        wr_en = 1'b0, wr_arm = 1'b0;
    logic [7:0]  ev_ch = '0, wr_ch = '0;
    logic [3:0]  ev_kind = '0;
    logic [13:0] rd_data;
    logic        irq, ovf;

    int total = 0;
    int bad   = 0;

    // Reference model state
    bit          m_en   [256];
    int          m_pend [256];
    int          q_ch[$];
    int          q_vec[$];
    bit          m_ovf = 1'b0;
    logic [13:0] m_rd = '0;

    always #10 clk = ~clk;

    inm_irq_notify u_inm_irq_notify (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ch(ev_ch),
        .ev_kind(ev_kind), .ev_desc(ev_desc), .rd_en(rd_en), .rd_data(rd_data),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_arm(wr_arm), .irq(irq), .ovf(ovf)
    );

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Apply pop, then write, then event to the model
    task automatic model(bit ev, int ech, int kind, bit desc, bit rd,
                         bit wr, int wch, bit arm);
        int v, idx;
        if (rd) begin
            if (q_ch.size() > 0) begin
                m_rd = {1'b1, 8'(q_ch[0]), 5'(q_vec[0])};
                void'(q_ch.pop_front());
                void'(q_vec.pop_front());
            end else
                m_rd = '0;
        end
        if (wr) begin
            if (!arm) m_en[wch] = 1'b0;
            else if (m_pend[wch] == 0) m_en[wch] = 1'b1;
            else begin
                m_en[wch] = 1'b0;
                if (q_ch.size() < 16) begin
                    q_ch.push_back(wch);
                    q_vec.push_back(m_pend[wch]);
                    m_pend[wch] = 0;
                end else m_ovf = 1'b1;
            end
        end
        v = (desc ? 16 : 0) | (kind & 15);
        if (ev && v != 0) begin
            idx = -1;
            foreach (q_ch[k]) if (q_ch[k] == ech) idx = k;
            if (idx >= 0) q_vec[idx] = q_vec[idx] | v;
            else if (m_en[ech]) begin
                m_en[ech] = 1'b0;
                if (q_ch.size() < 16) begin
                    q_ch.push_back(ech);
                    q_vec.push_back(m_pend[ech] | v);
                    m_pend[ech] = 0;
                end else begin
                    m_pend[ech] = m_pend[ech] | v;
                    m_ovf = 1'b1;
                end
            end else m_pend[ech] = m_pend[ech] | v;
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(string tag, bit ev, int ech, int kind, bit desc,
                        bit rd, bit wr, int wch, bit arm);
        ev_valid = ev; ev_ch = 8'(ech); ev_kind = 4'(kind); ev_desc = desc;
        rd_en = rd; wr_en = wr; wr_ch = 8'(wch); wr_arm = arm;
        @(posedge clk);
        model(ev, ech, kind, desc, rd, wr, wch, arm);
        @(negedge clk);
        check(tag, "rd_data", int'(rd_data), int'(m_rd));
        check(tag, "irq", int'(irq), (q_ch.size() != 0) ? 1 : 0);
        check(tag, "ovf", int'(ovf), int'(m_ovf));
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #3000000;
        bad++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, then an event on a never-armed channel stays quiet
        idle("R1");
        step("R1", 1, 5, 3, 0, 0, 0, 0, 0);
        // R3: accumulate more bits on the disarmed channel
        step("R3", 1, 5, 8, 0, 0, 0, 0, 0);
        // R4: arming with pending bits posts them
        step("R4", 0, 0, 0, 0, 0, 1, 5, 1);
        // R6 / R8: read returns {5, 01011}; irq drops after
        step("R6", 0, 0, 0, 0, 1, 0, 0, 0);
        idle("R8");
        // R4 arm without pending, R2 post, R5 merge, R10 descriptor bit
        step("R4", 0, 0, 0, 0, 0, 1, 7, 1);
        step("R2", 1, 7, 4, 0, 0, 0, 0, 0);
        step("R5", 1, 7, 1, 0, 0, 0, 0, 0);
        step("R10", 1, 7, 0, 1, 0, 0, 0, 0);
        step("R10", 1, 7, 0, 0, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 1, 0, 0, 0);
        // R12: disarm after arm, event goes pending
        step("R12", 0, 0, 0, 0, 0, 1, 7, 1);
        step("R12", 0, 0, 0, 0, 0, 1, 7, 0);
        step("R12", 1, 7, 2, 0, 0, 0, 0, 0);
        step("R12", 0, 0, 0, 0, 0, 1, 7, 1);
        step("R12", 0, 0, 0, 0, 1, 0, 0, 0);
        // R9: fill the list with 16 channels, then one more overflows
        for (int c = 10; c < 26; c++) begin
            step("R9", 0, 0, 0, 0, 0, 1, c, 1);
            step("R9", 1, c, c & 15 | 1, 0, 0, 0, 0, 0);
        end
        step("R9", 0, 0, 0, 0, 0, 1, 30, 1);
        step("R9", 1, 30, 6, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 1, 30, 1);
        for (int c = 0; c < 16; c++) step("R6", 0, 0, 0, 0, 1, 0, 0, 0);
        // R7: empty read
        step("R7", 0, 0, 0, 0, 1, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 1, 30, 1);
        step("R9", 0, 0, 0, 0, 1, 0, 0, 0);
        // R11: pop and event on the same channel in one cycle
        step("R11", 0, 0, 0, 0, 0, 1, 40, 1);
        step("R11", 1, 40, 1, 0, 0, 0, 0, 0);
        step("R11", 1, 40, 2, 0, 1, 0, 0, 0);
        step("R11", 0, 0, 0, 0, 0, 1, 40, 1);
        step("R11", 0, 0, 0, 0, 1, 0, 0, 0);
        // R11: arm write and event on the same channel in one cycle
        step("R11", 1, 41, 4, 0, 0, 1, 41, 1);
        step("R11", 0, 0, 0, 0, 1, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 1, 0, 0, 0);
        // R11 / R5: pseudo-random traffic on eight channels
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R11", lfsr[0], int'(lfsr[3:1]), int'(lfsr[7:4]), lfsr[8],
                 lfsr[9] & lfsr[10], lfsr[11] & lfsr[12], int'(lfsr[15:13]),
                 lfsr[2] | lfsr[5]);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule